// File: doc/BRIEF.md
# Master Clock Rate Detector and Sequencing Prescaler

This block runs in the master clock domain and measures how many master clock cycles lie between two rising edges of the 8 kHz transmit frame sync. It matches that count against seven supported master clock rates: 256, 512, 1536, 1544, 2048, 2560 and 4096 kHz. Once a rate is confirmed, it produces a single-cycle enable at an average of 256 kHz, which is 32 pulses per frame. The divide ratio is never programmed. It comes only from the detected rate.

The 1.544 MHz rate gives 193 cycles per frame, which does not divide evenly into 32 slots. For that rate the enable uses slots of six cycles, and the final slot of the frame is stretched by one cycle. The phase of the enable is restarted on every frame sync rising edge, so the pulse train stays aligned to the frame. Downstream logic uses the enable as a clock-enable and never as a clock.

Top module: `mclk_rate_prescaler`

## Requirements
- R1: A frame sync rising edge is the first cycle in which `fsync_i` is sampled high after being sampled low. The measured period is the number of `clk_i` cycles from one rising edge to the next. The first rising edge after reset only starts the count and yields no measurement.
- R2: The measured counts 32, 64, 192, 193, 256, 320 and 512 are reported on `rate_o` as codes 0, 1, 2, 3, 4, 5 and 6. Code 7 means no valid rate.
- R3: A count within one cycle of a supported value is accepted. An exact match takes priority over a neighbour, so 191 and 192 give code 2, while 193 and 194 give code 3.
- R4: `valid_o` rises only when two consecutive measurements classify to the same code. `valid_o` and `rate_o` change only at a rising edge, or at the timeout of R6, and they are visible in the cycle after that edge.
- R5: A measurement outside every tolerance window, or one whose code differs from the previous measurement, drives `valid_o` low, `rate_o` to 7 and `tick_o` low. After that, two further agreeing measurements are needed to lock again.
- R6: If no rising edge arrives within 1024 cycles of the last one, `valid_o` drops and `rate_o` becomes 7 in the following cycle. The stale history is discarded.
- R7: While valid, `tick_o` is a one-cycle pulse at the start of each slot. The slot length is 1, 2, 6, 8, 10 or 16 cycles for codes 0, 1, 2, 4, 5 and 6, which gives 32 pulses per frame at the nominal count. The first pulse is in the cycle right after the rising edge.
- R8: For code 3, slots 0 to 30 are 6 cycles long and slot 31 is 7 cycles long, so a 193-cycle frame carries exactly 32 pulses.
- R9: Every rising edge restarts the slot pattern at phase zero, even in the middle of a slot. If a frame runs past 32 slots, the pattern wraps and continues.
- R10: While `rst_ni` is low, `valid_o` is 0, `rate_o` is 7 and `tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | 8 kHz frame sync, synchronous to `clk_i` |
| tick_o | output | 1 | 256 kHz sequencing enable, one cycle wide |
| valid_o | output | 1 | Rate detected and confirmed |
| rate_o | output | 3 | Detected rate code, 7 when invalid |

## Verification
The bench drives frames of chosen lengths and predicts every output cycle from a frame-level model.

- **192 versus 193 overlap.** A classifier that resolves this overlap by list order alone would report 1536 kHz for a 193-cycle frame.
- **Slot 31 at 1.544 MHz.** A design that omits the stretched slot 31 would emit a 33rd pulse in that frame.
- **Short frame of 255 at 2048 kHz.** This checks the phase restart. A free-running divider would keep its old phase across the edge.
- **Unsupported count and alternating rates.** These catch a lock that trusts a single frame.
- **Over-long frame.** This catches a design that never drops lock when frame sync stops.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int NUM_RATES = 7;
  localparam int MAX_DIV   = 16;

  typedef logic [2:0] rate_code_t;
  localparam rate_code_t RATE_NONE = 3'd7;
  localparam rate_code_t ODD_CODE  = 3'd3;  // 193 cycles, stretched last slot

  function automatic int nominal_cycles(int idx);
    case (idx)
      0: return 32;
      1: return 64;
      2: return 192;
      3: return 193;
      4: return 256;
      5: return 320;
      default: return 512;
    endcase
  endfunction

  function automatic logic [4:0] divide_of(rate_code_t c);
    case (c)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2, 3'd3: return 5'd6;
      3'd4: return 5'd8;
      3'd5: return 5'd10;
      3'd6: return 5'd16;
      default: return 5'd1;
    endcase
  endfunction

  // exact match wins over a tolerance neighbour
  function automatic rate_code_t classify(int n, int tol);
    rate_code_t res;
    logic hit;
    res = RATE_NONE;
    hit = 1'b0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (!hit && n == nominal_cycles(i)) begin
        res = rate_code_t'(i);
        hit = 1'b1;
      end
    end
    for (int i = 0; i < NUM_RATES; i++) begin
      if (!hit && n + tol >= nominal_cycles(i) && n <= nominal_cycles(i) + tol) begin
        res = rate_code_t'(i);
        hit = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/mrp_period_meas.sv
module mrp_period_meas #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic             rise_o,
  output logic             meas_stb_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fs_q;
  logic             started_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise_o     = fsync_i & ~fs_q;
  assign meas_stb_o = rise_o & started_q;
  assign meas_o     = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
  assign timeout_o  = started_q & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q      <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      fs_q <= fsync_i;
      if (rise_o) begin
        cnt_q     <= '0;
        started_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mrp_rate_lock.sv
module mrp_rate_lock
  import mrp_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_stb_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             timeout_i,
  output logic             valid_o,
  output rate_code_t       rate_o
);
  rate_code_t cls;
  rate_code_t prev_q;

  always_comb cls = classify(int'(meas_i), TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rate_o  <= RATE_NONE;
      prev_q  <= RATE_NONE;
    end else if (meas_stb_i) begin
      prev_q <= cls;
      if (cls != RATE_NONE && cls == prev_q) begin
        valid_o <= 1'b1;
        rate_o  <= cls;
      end else begin
        valid_o <= 1'b0;
        rate_o  <= RATE_NONE;
      end
    end else if (timeout_i) begin
      valid_o <= 1'b0;
      rate_o  <= RATE_NONE;
      prev_q  <= RATE_NONE;
    end
  end
endmodule

// File: rtl/mrp_tick_gen.sv
module mrp_tick_gen
  import mrp_pkg::*;
#(
  parameter int FRAME_TICKS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       valid_i,
  input  rate_code_t rate_i,
  output logic       tick_o
);
  localparam int SLOT_W = $clog2(FRAME_TICKS);
  localparam int PH_W   = $clog2(MAX_DIV + 2);

  logic [PH_W-1:0]   ph_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PH_W-1:0]   len_m1;
  logic              stretch;

  assign stretch = (rate_i == ODD_CODE) && (slot_q == SLOT_W'(FRAME_TICKS - 1));
  assign len_m1  = PH_W'(divide_of(rate_i)) - PH_W'(1) + PH_W'(stretch);
  assign tick_o  = valid_i && (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      slot_q <= '0;
    end else if (rise_i) begin
      ph_q   <= '0;
      slot_q <= '0;
    end else if (ph_q >= len_m1) begin
      ph_q   <= '0;
      slot_q <= slot_q + SLOT_W'(1);
    end else begin
      ph_q <= ph_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/mclk_rate_prescaler.sv
module mclk_rate_prescaler
  import mrp_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 1,
  parameter int FRAME_TICKS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fsync_i,
  output logic       tick_o,
  output logic       valid_o,
  output logic [2:0] rate_o
);
  logic             rise;
  logic             meas_stb;
  logic [CNT_W-1:0] meas;
  logic             timeout;
  rate_code_t       rate;

  mrp_period_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .rise_o     (rise),
    .meas_stb_o (meas_stb),
    .meas_o     (meas),
    .timeout_o  (timeout)
  );

  mrp_rate_lock #(.CNT_W(CNT_W), .TOL(TOL)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_stb_i (meas_stb),
    .meas_i     (meas),
    .timeout_i  (timeout),
    .valid_o    (valid_o),
    .rate_o     (rate)
  );

  mrp_tick_gen #(.FRAME_TICKS(FRAME_TICKS)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .valid_i (valid_o),
    .rate_i  (rate),
    .tick_o  (tick_o)
  );

  assign rate_o = rate;
endmodule

// File: rtl/mrp_chk.sv
module mrp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rise_i,
  input logic       timeout_i,
  input logic       tick_i,
  input logic       valid_i,
  input logic [2:0] rate_i
);
  // R4
  valid_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> rate_i != 3'd7);

  // R5
  invalid_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> rate_i == 3'd7);

  // R4
  hold_between_edges_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !timeout_i) |=> ($stable(rate_i) && $stable(valid_i)));

  // R9
  tick_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (tick_i == valid_i));

  // R7
  single_cycle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && valid_i && rate_i != 3'd0 && !rise_i) |=> !tick_i);

  // R7
  full_rate_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rate_i == 3'd0 && !rise_i && !timeout_i) |=> tick_i);
endmodule

bind mclk_rate_prescaler mrp_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rise_i    (rise),
  .timeout_i (timeout),
  .tick_i    (tick_o),
  .valid_i   (valid_o),
  .rate_i    (rate_o)
);

// File: tb/sim_mclk_rate_prescaler.sv
module sim_mclk_rate_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  typedef struct {
    logic       tick;
    logic       valid;
    logic [2:0] rate;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fsync_i = 1'b0;
  logic       tick_o;
  logic       valid_o;
  logic [2:0] rate_o;

  int checks = 0;
  int fails  = 0;
  exp_t sb_q[$];

  // model state
  int prev_len = -1;
  int prev_cls = 7;
  bit m_valid  = 1'b0;
  int m_rate   = 7;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_rate_prescaler u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .tick_o  (tick_o),
    .valid_o (valid_o),
    .rate_o  (rate_o)
  );

  function automatic int nom(int i);
    int t[7] = '{32, 64, 192, 193, 256, 320, 512};
    return t[i];
  endfunction

  function automatic int m_classify(int n);
    for (int i = 0; i < 7; i++) if (n == nom(i)) return i;
    for (int i = 0; i < 7; i++) if (n >= nom(i) - 1 && n <= nom(i) + 1) return i;
    return 7;
  endfunction

  function automatic bit tick_at(int code, int j);
    int d[7] = '{1, 2, 6, 6, 8, 10, 16};
    int p;
    int jj;
    if (code > 6) return 1'b0;
    p  = (code == 3) ? 193 : 32 * d[code];
    jj = j % p;
    if (code == 3) return (jj <= 186) && (jj % 6 == 0);
    return (jj % d[code]) == 0;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (tick_o !== e.tick || valid_o !== e.valid || rate_o !== e.rate[2:0]) begin
      fails++;
      $display("FAIL %s: tick=%0b valid=%0b rate=%0d expected tick=%0b valid=%0b rate=%0d",
               e.tag, tick_o, valid_o, rate_o, e.tick, e.valid, e.rate);
    end
  endtask

  task automatic run_frame(int n, string tag);
    exp_t e;
    if (prev_len >= 0) begin
      int c;
      c = m_classify(prev_len > 1023 ? 1023 : prev_len);
      if (c != 7 && c == prev_cls) begin
        m_valid = 1'b1;
        m_rate  = c;
      end else begin
        m_valid = 1'b0;
        m_rate  = 7;
      end
      prev_cls = c;
    end
    prev_len = n;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      fsync_i = (j == 0);
      @(posedge clk);
      if (j == 1024) begin
        m_valid  = 1'b0;
        m_rate   = 7;
        prev_cls = 7;
      end
      e.tick  = m_valid && tick_at(m_rate, j);
      e.valid = m_valid;
      e.rate  = 3'(m_rate);
      e.tag   = tag;
      sb_q.push_back(e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      compare(e);
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    exp_t r;
    r.tick = 1'b0; r.valid = 1'b0; r.rate = 3'd7; r.tag = "R10";
    repeat (3) @(negedge clk);
    compare(r);  // R10 during reset
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare(r);  // R10 after release, idle
    end

    run_frame(32, "R1");
    run_frame(32, "R1");
    repeat (3) run_frame(32, "R2/R7");
    repeat (3) run_frame(64, "R2/R7");
    repeat (3) run_frame(192, "R2/R7");
    repeat (3) run_frame(193, "R2/R8");
    repeat (3) run_frame(256, "R2/R7");
    repeat (3) run_frame(320, "R2/R7");
    repeat (3) run_frame(512, "R2/R7");

    repeat (3) run_frame(191, "R3");
    repeat (3) run_frame(194, "R3");
    repeat (3) run_frame(33, "R3");
    repeat (3) run_frame(511, "R3");

    repeat (2) run_frame(256, "R9");
    repeat (3) run_frame(255, "R9");

    run_frame(100, "R5");
    repeat (3) run_frame(256, "R5");

    repeat (2) begin
      run_frame(256, "R4");
      run_frame(320, "R4");
    end
    repeat (3) run_frame(320, "R4");

    run_frame(1100, "R6");
    repeat (3) run_frame(64, "R6");

    @(negedge clk);
    fsync_i = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule